// File: doc/BRIEF.md
# Instruction decode control unit

This block turns one 16-bit instruction word into every control signal that a single-cycle, four-register processor datapath needs in the same cycle. It is purely combinational. The top four bits pick one of sixteen operations. Two 2-bit fields name a destination and a source register. The low byte holds an immediate, and that byte also decides the operand form: the all-ones value 0xFF marks a register-only instruction, and any other value marks the immediate form. The immediate is always presented zero-extended to 16 bits.

The datapath uses the outputs to choose the ALU operation and its second operand, the value written back to the register file, the register that forms a data-memory address, the branch condition with its target source, flag updates and halting. Each control output rests at its inactive value unless the current opcode needs it, so an unknown or unused encoding cannot start a write.

Top module: `idc_decoder`

## Requirements
- R1: Bits 15:12 are the opcode, bits 11:10 go to `dst_idx_o`, bits 9:8 go to `src_idx_o`, and `imm_ext_o` is bits 7:0 zero-extended to 16 bits.
- R2: For opcodes 0 and 2 to 7, `opb_imm_o` is 1 when the low byte is anything other than 0xFF and 0 when it equals 0xFF. For all other opcodes it is 0.
- R3: Opcode 1 (invert) gives `alu_op_o`=1 and `opb_imm_o`=0, with register write and flag update enabled. Its controls do not depend on the source field or the low byte.
- R4: `alu_op_o` equals the opcode for opcodes 0 to 7 (0 OR, 1 NOT, 2 AND, 3 XOR, 4 ADD, 5 SUB, 6 MUL, 7 DIV) and is 8 (idle) for every other opcode.
- R5: `reg_we_o` is 1 for opcodes 0 to 10 and 0 for opcodes 11 to 15.
- R6: `flag_we_o` is 1 only for opcodes 0 to 7.
- R7: `wb_sel_o` encodes the write-back source: 0 ALU, 1 source register, 2 immediate, 3 memory. Opcode 8 gives 1, opcode 9 gives 2, opcode 10 gives 3, and every other opcode gives 0.
- R8: `mem_addr_src_o` is 1 (address from the source register) for opcode 10 (load) and 0 (address from the destination register) otherwise. `mem_we_o` is 1 only for opcode 11 (store), which writes the source register's value.
- R9: `br_cond_o` is 1 (zero) for opcode 12, 2 (negative) for opcode 13, 3 (positive) for opcode 14, and 0 (no branch) otherwise.
- R10: For opcodes 12 to 14, `br_tgt_imm_o` is 0 (target from the destination register) when the low byte is 0xFF and 1 (target from the zero-extended immediate) otherwise. For all other opcodes it is 0.
- R11: `halt_o` is 1 only for opcode 15, and under opcode 15 no write, flag or branch output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| alu_op_o | output | 4 | ALU operation select, 8 = idle |
| opb_imm_o | output | 1 | ALU second operand: 1 immediate, 0 source register |
| dst_idx_o | output | 2 | Destination register index |
| src_idx_o | output | 2 | Source register index |
| imm_ext_o | output | 16 | Zero-extended immediate |
| reg_we_o | output | 1 | Register file write enable |
| wb_sel_o | output | 2 | Write-back source select |
| mem_we_o | output | 1 | Data memory write enable |
| mem_addr_src_o | output | 1 | Memory address register: 1 source, 0 destination |
| br_cond_o | output | 2 | Branch condition: 0 none, 1 zero, 2 negative, 3 positive |
| br_tgt_imm_o | output | 1 | Branch target: 1 immediate, 0 destination register |
| flag_we_o | output | 1 | Flag update enable |
| halt_o | output | 1 | Stop request |

## Verification
The block holds no state, so any fault in its field split, opcode one-hot or control table shows at the ports in the same cycle that the faulty instruction word is applied. A wrong operand-form detection shows up as a flipped operand or branch-target select exactly when the low byte is at or next to 0xFF. A wrong one-hot bit shows up as a write enable or branch code on the wrong opcode. The bench therefore applies every opcode against low-byte values around 0x00, 0x7F/0x80 and 0xFE/0xFF, with several register fields, and compares every output.

// File: rtl/idc_pkg.sv
package idc_pkg;

   localparam int unsigned OPC_BITS = 4;
   localparam int unsigned NUM_OPS  = 1 << OPC_BITS;

   // opcode assignments
   localparam logic [OPC_BITS-1:0] OP_OR    = 4'd0;
   localparam logic [OPC_BITS-1:0] OP_NOT   = 4'd1;
   localparam logic [OPC_BITS-1:0] OP_DIV   = 4'd7;
   localparam logic [OPC_BITS-1:0] OP_MOVR  = 4'd8;
   localparam logic [OPC_BITS-1:0] OP_MOVI  = 4'd9;
   localparam logic [OPC_BITS-1:0] OP_LOAD  = 4'd10;
   localparam logic [OPC_BITS-1:0] OP_STORE = 4'd11;
   localparam logic [OPC_BITS-1:0] OP_JZ    = 4'd12;
   localparam logic [OPC_BITS-1:0] OP_JN    = 4'd13;
   localparam logic [OPC_BITS-1:0] OP_JP    = 4'd14;
   localparam logic [OPC_BITS-1:0] OP_HALT  = 4'd15;

   localparam logic [3:0] ALU_IDLE = 4'd8;

   typedef enum logic [1:0] {
      WB_ALU = 2'd0,
      WB_SRC = 2'd1,
      WB_IMM = 2'd2,
      WB_MEM = 2'd3
   } wb_src_e;

   typedef enum logic [1:0] {
      BR_NONE = 2'd0,
      BR_ZERO = 2'd1,
      BR_NEG  = 2'd2,
      BR_POS  = 2'd3
   } br_cond_e;

   typedef struct packed {
      logic [3:0] alu_op;
      logic       opb_imm;
      logic       reg_we;
      wb_src_e    wb_sel;
      logic       mem_we;
      logic       addr_src;
      br_cond_e   br_cond;
      logic       tgt_imm;
      logic       flag_we;
      logic       halt;
   } ctrl_t;

endpackage

// File: rtl/idc_fields.sv
module idc_fields #(
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned OPC_W   = 4,
   parameter int unsigned RSEL_W  = 2,
   parameter int unsigned IMM_W   = 8,
   parameter int unsigned XDATA_W = 16,
   parameter logic [IMM_W-1:0] REGFORM_MARK = '1
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [OPC_W-1:0]   opc_o,
   output logic [RSEL_W-1:0]  dst_o,
   output logic [RSEL_W-1:0]  src_o,
   output logic [XDATA_W-1:0] imm_ext_o,
   output logic               reg_only_o
);

   localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
   localparam int unsigned DST_LSB = OPC_LSB - RSEL_W;
   localparam int unsigned SRC_LSB = DST_LSB - RSEL_W;
   localparam bit          MARK_ONES = (REGFORM_MARK == {IMM_W{1'b1}});

   generate
      if (INSTR_W != OPC_W + 2 * RSEL_W + IMM_W) begin : g_bad_split
         $error("idc_fields: field widths do not fill the instruction word");
      end
      if (XDATA_W < IMM_W) begin : g_bad_ext
         $error("idc_fields: extended immediate narrower than the immediate field");
      end
   endgenerate

   logic [IMM_W-1:0] imm_raw;

   assign opc_o   = instr_i[INSTR_W-1 -: OPC_W];
   assign dst_o   = instr_i[DST_LSB +: RSEL_W];
   assign src_o   = instr_i[SRC_LSB +: RSEL_W];
   assign imm_raw = instr_i[IMM_W-1:0];
   assign imm_ext_o = XDATA_W'(imm_raw);

   // operand form: the whole low byte is compared with the marker
   generate
      if (MARK_ONES) begin : g_mark_and
         assign reg_only_o = &imm_raw;
      end else begin : g_mark_eq
         assign reg_only_o = (imm_raw == REGFORM_MARK);
      end
   endgenerate

endmodule

// File: rtl/idc_onehot.sv
module idc_onehot #(
   parameter int unsigned OPC_W = 4,
   localparam int unsigned N_OPS = 1 << OPC_W
) (
   input  logic [OPC_W-1:0] opc_i,
   output logic [N_OPS-1:0] hot_o
);

   generate
      for (genvar k = 0; k < N_OPS; k++) begin : g_hot
         assign hot_o[k] = (opc_i == OPC_W'(k));
      end
   endgenerate

endmodule

// File: rtl/idc_ctrl.sv
module idc_ctrl
   import idc_pkg::*;
#(
   parameter int unsigned OPC_W = 4,
   localparam int unsigned N_OPS = 1 << OPC_W
) (
   input  logic [OPC_W-1:0] opc_i,
   input  logic [N_OPS-1:0] hot_i,
   input  logic             reg_only_i,
   output ctrl_t            ctrl_o
);

   generate
      if (OPC_W != OPC_BITS) begin : g_bad_opc
         $error("idc_ctrl: opcode width must match the sixteen-entry table");
      end
   endgenerate

   logic is_arith;
   logic is_jump;

   // two-operand ALU group: opcodes 0 and 2..7
   assign is_arith = hot_i[0] | (|hot_i[7:2]);
   assign is_jump  = |hot_i[14:12];

   always_comb begin
      ctrl_o          = '0;
      ctrl_o.alu_op   = ALU_IDLE;
      ctrl_o.wb_sel   = WB_ALU;
      ctrl_o.br_cond  = BR_NONE;

      if (is_arith) begin
         ctrl_o.alu_op  = 4'(opc_i);
         ctrl_o.opb_imm = ~reg_only_i;
         ctrl_o.reg_we  = 1'b1;
         ctrl_o.flag_we = 1'b1;
      end

      if (hot_i[OP_NOT]) begin
         ctrl_o.alu_op  = 4'(OP_NOT);
         ctrl_o.reg_we  = 1'b1;
         ctrl_o.flag_we = 1'b1;
      end

      if (hot_i[OP_MOVR]) begin
         ctrl_o.reg_we = 1'b1;
         ctrl_o.wb_sel = WB_SRC;
      end

      if (hot_i[OP_MOVI]) begin
         ctrl_o.reg_we = 1'b1;
         ctrl_o.wb_sel = WB_IMM;
      end

      if (hot_i[OP_LOAD]) begin
         ctrl_o.reg_we   = 1'b1;
         ctrl_o.wb_sel   = WB_MEM;
         ctrl_o.addr_src = 1'b1;
      end

      if (hot_i[OP_STORE]) begin
         ctrl_o.mem_we = 1'b1;
      end

      if (is_jump) begin
         ctrl_o.tgt_imm = ~reg_only_i;
         unique case (1'b1)
            hot_i[OP_JZ]: ctrl_o.br_cond = BR_ZERO;
            hot_i[OP_JN]: ctrl_o.br_cond = BR_NEG;
            default:      ctrl_o.br_cond = BR_POS;
         endcase
      end

      if (hot_i[OP_HALT]) begin
         ctrl_o.halt = 1'b1;
      end
   end

endmodule

// File: rtl/idc_decoder.sv
module idc_decoder
   import idc_pkg::*;
#(
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned OPC_W   = 4,
   parameter int unsigned RSEL_W  = 2,
   parameter int unsigned IMM_W   = 8,
   parameter int unsigned XDATA_W = 16,
   localparam int unsigned N_OPS  = 1 << OPC_W
) (
   input  logic [INSTR_W-1:0] instr_i,
   output logic [3:0]         alu_op_o,
   output logic               opb_imm_o,
   output logic [RSEL_W-1:0]  dst_idx_o,
   output logic [RSEL_W-1:0]  src_idx_o,
   output logic [XDATA_W-1:0] imm_ext_o,
   output logic               reg_we_o,
   output logic [1:0]         wb_sel_o,
   output logic               mem_we_o,
   output logic               mem_addr_src_o,
   output logic [1:0]         br_cond_o,
   output logic               br_tgt_imm_o,
   output logic               flag_we_o,
   output logic               halt_o
);

   logic [OPC_W-1:0] opc;
   logic [N_OPS-1:0] hot;
   logic             reg_only;
   ctrl_t            ctrl;

   idc_fields #(
      .INSTR_W (INSTR_W),
      .OPC_W   (OPC_W),
      .RSEL_W  (RSEL_W),
      .IMM_W   (IMM_W),
      .XDATA_W (XDATA_W)
   ) u_fields (
      .instr_i    (instr_i),
      .opc_o      (opc),
      .dst_o      (dst_idx_o),
      .src_o      (src_idx_o),
      .imm_ext_o  (imm_ext_o),
      .reg_only_o (reg_only)
   );

   idc_onehot #(.OPC_W(OPC_W)) u_onehot (
      .opc_i (opc),
      .hot_o (hot)
   );

   idc_ctrl #(.OPC_W(OPC_W)) u_ctrl (
      .opc_i      (opc),
      .hot_i      (hot),
      .reg_only_i (reg_only),
      .ctrl_o     (ctrl)
   );

   assign alu_op_o       = ctrl.alu_op;
   assign opb_imm_o      = ctrl.opb_imm;
   assign reg_we_o       = ctrl.reg_we;
   assign wb_sel_o       = ctrl.wb_sel;
   assign mem_we_o       = ctrl.mem_we;
   assign mem_addr_src_o = ctrl.addr_src;
   assign br_cond_o      = ctrl.br_cond;
   assign br_tgt_imm_o   = ctrl.tgt_imm;
   assign flag_we_o      = ctrl.flag_we;
   assign halt_o         = ctrl.halt;

   always_comb begin
      if (!$isunknown(instr_i)) begin
         // R8
         one_writer_chk: assert (!(reg_we_o && mem_we_o))
            else $error("register and memory writes both enabled");
         // R11
         halt_quiet_chk: assert (!halt_o || (!reg_we_o && !mem_we_o && !flag_we_o && br_cond_o == 2'd0))
            else $error("halt with a side effect active");
         // R6
         flag_wb_chk: assert (!flag_we_o || (reg_we_o && wb_sel_o == 2'd0))
            else $error("flag update outside an ALU write-back");
         // R9
         branch_nowrite_chk: assert (br_cond_o == 2'd0 || (!reg_we_o && !mem_we_o))
            else $error("branch with a write enabled");
         // R2
         imm_form_chk: assert (!(opb_imm_o || br_tgt_imm_o) || !reg_only)
            else $error("immediate selected for a register-only word");
         // R4
         one_hot_chk: assert ($onehot(hot))
            else $error("opcode decode not one-hot");
      end
   end

endmodule

// File: tb/idc_decoder_bench.sv
module idc_decoder_bench;

   logic        clk;
   logic        rst_n;
   logic [15:0] instr;
   logic [3:0]  alu_op;
   logic        opb_imm;
   logic [1:0]  dst_idx;
   logic [1:0]  src_idx;
   logic [15:0] imm_ext;
   logic        reg_we;
   logic [1:0]  wb_sel;
   logic        mem_we;
   logic        addr_src;
   logic [1:0]  br_cond;
   logic        tgt_imm;
   logic        flag_we;
   logic        halt;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   idc_decoder u_idc_decoder (
      .instr_i        (instr),
      .alu_op_o       (alu_op),
      .opb_imm_o      (opb_imm),
      .dst_idx_o      (dst_idx),
      .src_idx_o      (src_idx),
      .imm_ext_o      (imm_ext),
      .reg_we_o       (reg_we),
      .wb_sel_o       (wb_sel),
      .mem_we_o       (mem_we),
      .mem_addr_src_o (addr_src),
      .br_cond_o      (br_cond),
      .br_tgt_imm_o   (tgt_imm),
      .flag_we_o      (flag_we),
      .halt_o         (halt)
   );

   initial clk = 0;
   always #2 clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s instr=%h actual=%0d expected=%0d", req, what, instr, act, exp);
      end
   endtask

   // apply on the falling edge, sample one ns later (combinational path)
   task automatic apply(input logic [15:0] w);
      @(negedge clk);
      instr = w;
      #1;
   endtask

   function automatic logic [15:0] mk(input int op, input int d, input int s, input int lo);
      return {4'(op), 2'(d), 2'(s), 8'(lo)};
   endfunction

   // expectation from the requirement text
   task automatic check_all(input logic [15:0] w);
      int op;
      bit ro;
      op = int'(w[15:12]);
      ro = (w[7:0] == 8'hFF);
      apply(w);
      chk("R1", "dst", int'(dst_idx), int'(w[11:10]));
      chk("R1", "src", int'(src_idx), int'(w[9:8]));
      chk("R1", "imm", int'(imm_ext), int'(w[7:0]));
      chk("R4", "alu_op", int'(alu_op), (op <= 7) ? op : 8);
      chk("R2", "opb_imm", int'(opb_imm), (op <= 7 && op != 1 && !ro) ? 1 : 0);
      chk("R5", "reg_we", int'(reg_we), (op <= 10) ? 1 : 0);
      chk("R6", "flag_we", int'(flag_we), (op <= 7) ? 1 : 0);
      chk("R7", "wb_sel", int'(wb_sel), (op == 8) ? 1 : (op == 9) ? 2 : (op == 10) ? 3 : 0);
      chk("R8", "mem_we", int'(mem_we), (op == 11) ? 1 : 0);
      chk("R8", "addr_src", int'(addr_src), (op == 10) ? 1 : 0);
      chk("R9", "br_cond", int'(br_cond), (op == 12) ? 1 : (op == 13) ? 2 : (op == 14) ? 3 : 0);
      chk("R10", "tgt_imm", int'(tgt_imm), (op >= 12 && op <= 14 && !ro) ? 1 : 0);
      chk("R11", "halt", int'(halt), (op == 15) ? 1 : 0);
   endtask

   task automatic t_idle_word();
      check_all(16'h0000);
      chk("R1", "zero word imm", int'(imm_ext), 0);
   endtask

   task automatic t_fields();
      check_all(mk(4, 3, 1, 8'hA5));
      chk("R1", "imm upper byte", int'(imm_ext[15:8]), 0);
      check_all(mk(9, 2, 3, 8'h80));
      chk("R1", "imm high bit", int'(imm_ext), 16'h0080);
   endtask

   task automatic t_alu_forms();
      for (int op = 0; op < 8; op++) begin
         if (op == 1) continue;
         check_all(mk(op, 1, 2, 8'hFF));
         chk("R2", "reg form", int'(opb_imm), 0);
         check_all(mk(op, 1, 2, 8'hFE));
         chk("R2", "imm form", int'(opb_imm), 1);
      end
   endtask

   task automatic t_not_ignores_src();
      logic [31:0] ref_v;
      check_all(mk(1, 2, 0, 8'h00));
      ref_v = {alu_op, opb_imm, reg_we, wb_sel, mem_we, addr_src, br_cond, tgt_imm, flag_we, halt, 14'd0};
      for (int s = 0; s < 4; s++) begin
         for (int b = 0; b < 3; b++) begin
            check_all(mk(1, 2, s, (b == 0) ? 8'h00 : (b == 1) ? 8'h5A : 8'hFF));
            chk("R3", "not stable vs src", int'({alu_op, opb_imm, reg_we, wb_sel, mem_we, addr_src,
                br_cond, tgt_imm, flag_we, halt, 14'd0} == ref_v), 1);
            chk("R3", "not opb", int'(opb_imm), 0);
         end
      end
   endtask

   task automatic t_moves();
      check_all(mk(8, 0, 3, 8'hFF));
      chk("R7", "mov reg wb", int'(wb_sel), 1);
      check_all(mk(9, 3, 0, 8'h2C));
      chk("R7", "mov imm wb", int'(wb_sel), 2);
   endtask

   task automatic t_mem();
      check_all(mk(10, 1, 2, 8'hFF));
      chk("R8", "load addr from src", int'(addr_src), 1);
      chk("R7", "load wb mem", int'(wb_sel), 3);
      check_all(mk(11, 1, 2, 8'hFF));
      chk("R8", "store addr from dst", int'(addr_src), 0);
      chk("R8", "store write", int'(mem_we), 1);
      chk("R5", "store no reg write", int'(reg_we), 0);
   endtask

   task automatic t_jumps();
      for (int op = 12; op < 15; op++) begin
         check_all(mk(op, 3, 0, 8'hFF));
         chk("R10", "jump reg target", int'(tgt_imm), 0);
         check_all(mk(op, 0, 0, 8'h10));
         chk("R10", "jump imm target", int'(tgt_imm), 1);
         chk("R9", "jump code", int'(br_cond), op - 11);
      end
   endtask

   task automatic t_halt();
      check_all(mk(15, 3, 3, 8'h00));
      chk("R11", "halt quiet", int'(reg_we | mem_we | flag_we | (|br_cond)), 0);
      check_all(mk(15, 0, 1, 8'hFF));
   endtask

   task automatic t_sweep();
      int lows [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
      for (int op = 0; op < 16; op++) begin
         for (int i = 0; i < 6; i++) begin
            check_all(mk(op, (op + i) % 4, (op * 3 + i) % 4, lows[i]));
         end
      end
   endtask

   initial begin
      instr = 16'h0000;
      rst_n = 0;
      repeat (3) @(posedge clk);
      rst_n = 1;
      t_idle_word();
      t_fields();
      t_alu_forms();
      t_not_ignores_src();
      t_moves();
      t_mem();
      t_jumps();
      t_halt();
      t_sweep();
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (200000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule